// File: doc/BRIEF.md
# Dithered Ramp Stimulus Generator

This block produces the code stream for a high-resolution stimulus DAC that exercises a lower-resolution ADC during a static linearity test. Each accepted sample moves a ramp up by exactly one ADC step, so every ADC code receives one hit. A small deterministic offset is added to each sample. The offset comes from a 3-bit maximal-length pseudo-random sequence, which cycles through seven equally spaced values. The net dither spans less than one ADC step, and its effect is to average out the quantization bias that a clean ramp leaves in each code segment.

Alongside the DAC code, the block emits the undithered ramp index. The linearity estimator uses this index as its expected ADC code. Samples leave on a valid/ready stream. A sample is held unchanged while `out_ready` is low, and the ramp and the sequence advance only on a cycle where both `out_valid` and `out_ready` are high. A one-cycle `start_i` pulse begins a run, and `done` reports that the run has completed.

Top module: `ramp_dither_gen`

## Requirements
- R1: After reset `out_valid` and `done` are low, and they stay low while idle whatever `out_ready` does.
- R2: In the cycle after `start_i` is sampled high, `out_valid` is high, `adc_code` is 0 and the sequence state is 1.
- R3: Every handshake (`out_valid` and `out_ready` high) raises `adc_code` by one. While `out_valid` is high and `out_ready` is low, `out_valid`, `adc_code` and `dac_code` hold their values.
- R4: The sequence state starts at 1 and steps once per handshake through 1, 2, 5, 3, 7, 6, 4, then repeats. This is the feedback x^3 + x^2 + 1, with the new bit shifted in at the bottom. The dither offset is (state − 4) × DITH_STEP DAC codes, which gives ±96 by default (±3/8 of an ADC step).
- R5: `dac_code` equals `adc_code` × 2^(DAC_W−ADC_W) plus the offset, clamped to the range 0 to 2^DAC_W − 1. The first sample of a default run is therefore 0.
- R6: The handshake that accepts index NUM_SAMPLES−1 (4095 by default) ends the run. `out_valid` falls in the next cycle, `done` rises, and `done` holds until the next start.
- R7: A `start_i` pulse during a run restarts the ramp at 0 and the sequence at state 1.
- R8: A `start_i` pulse after completion clears `done` in the next cycle and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins or restarts a run |
| out_ready | input | 1 | Consumer accepts the current sample |
| out_valid | output | 1 | A sample is presented |
| dac_code | output | DAC_W (20) | Dithered DAC code |
| adc_code | output | ADC_W (12) | Undithered ramp index (expected ADC code) |
| done | output | 1 | Run complete, held until the next start |

## Verification
The upper clamp is the hardest case to reach. With the default widths, the top ramp value plus the largest offset stays below full scale, so the clamp never engages from the ports. To reach it, the bench runs a second instance with equal DAC and ADC widths and a larger dither step. Both instances get the same stimulus, and the bench checks that the positive offsets near the top of that instance's ramp saturate at full scale. Run completion and sequence phase are reached through a full 4096-sample run under random back-pressure, with random restarts mixed in beforehand.

// File: rtl/ramp_dither_pkg.sv
package ramp_dither_pkg;

  localparam int unsigned SEQ_W = 3;
  localparam logic [SEQ_W-1:0] SEQ_SEED = 3'b001;
  localparam int SEQ_MID = 4;

  // x^3 + x^2 + 1, new bit enters at the bottom
  function automatic logic [SEQ_W-1:0] seq_next(input logic [SEQ_W-1:0] s);
    return {s[1:0], s[2] ^ s[1]};
  endfunction

endpackage

// File: rtl/ramp_dither_seq.sv
module ramp_dither_seq
  import ramp_dither_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reseed,
  input  logic             step,
  output logic [SEQ_W-1:0] state
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_SEED;
    end else if (reseed) begin
      state <= SEQ_SEED;
    end else if (step) begin
      state <= seq_next(state);
    end
  end

endmodule

// File: rtl/ramp_dither_ctr.sv
module ramp_dither_ctr #(
  parameter int unsigned ADC_W       = 12,
  parameter int unsigned NUM_SAMPLES = 1 << ADC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  output logic [ADC_W-1:0] ramp,
  output logic             running,
  output logic             done
);

  localparam logic [ADC_W-1:0] LAST = ADC_W'(NUM_SAMPLES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ramp    <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      ramp    <= '0;
      running <= 1'b1;
      done    <= 1'b0;
    end else if (step) begin
      if (ramp == LAST) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        ramp <= ramp + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ramp_dither_map.sv
module ramp_dither_map
  import ramp_dither_pkg::*;
#(
  parameter int unsigned DAC_W     = 20,
  parameter int unsigned ADC_W     = 12,
  parameter int unsigned DITH_STEP = 32
) (
  input  logic [ADC_W-1:0] ramp,
  input  logic [SEQ_W-1:0] state,
  output logic [DAC_W-1:0] dac_code
);

  localparam int unsigned SHIFT = DAC_W - ADC_W;
  localparam int unsigned SW    = DAC_W + 2;
  localparam logic signed [SW-1:0] TOP = {2'b00, {DAC_W{1'b1}}};

  logic [SW-1:0]        base;
  int                   off_i;
  logic signed [SW-1:0] sum;

  always_comb begin
    base  = SW'(ramp) << SHIFT;
    off_i = (int'(state) - SEQ_MID) * int'(DITH_STEP);
    sum   = $signed(base) + $signed(SW'(off_i));
    if (sum < 0) begin
      dac_code = '0;
    end else if (sum > TOP) begin
      dac_code = {DAC_W{1'b1}};
    end else begin
      dac_code = sum[DAC_W-1:0];
    end
  end

endmodule

// File: rtl/ramp_dither_gen.sv
module ramp_dither_gen
  import ramp_dither_pkg::*;
#(
  parameter int unsigned DAC_W       = 20,
  parameter int unsigned ADC_W       = 12,
  parameter int unsigned DITH_STEP   = 32,
  parameter int unsigned NUM_SAMPLES = 1 << ADC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [DAC_W-1:0] dac_code,
  output logic [ADC_W-1:0] adc_code,
  output logic             done
);

  logic             running;
  logic             accept;
  logic [SEQ_W-1:0] seq_state;
  logic [ADC_W-1:0] ramp;

  assign accept    = running & out_ready;
  assign out_valid = running;
  assign adc_code  = ramp;

  ramp_dither_ctr #(
    .ADC_W       (ADC_W),
    .NUM_SAMPLES (NUM_SAMPLES)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_i),
    .step    (accept),
    .ramp    (ramp),
    .running (running),
    .done    (done)
  );

  ramp_dither_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .reseed (start_i),
    .step   (accept),
    .state  (seq_state)
  );

  ramp_dither_map #(
    .DAC_W     (DAC_W),
    .ADC_W     (ADC_W),
    .DITH_STEP (DITH_STEP)
  ) u_map (
    .ramp     (ramp),
    .state    (seq_state),
    .dac_code (dac_code)
  );

endmodule

// File: rtl/ramp_dither_chk.sv
module ramp_dither_chk #(
  parameter int unsigned DAC_W       = 20,
  parameter int unsigned ADC_W       = 12,
  parameter int unsigned DITH_STEP   = 32,
  parameter int unsigned NUM_SAMPLES = 1 << ADC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             out_ready,
  input logic             out_valid,
  input logic [DAC_W-1:0] dac_code,
  input logic [ADC_W-1:0] adc_code,
  input logic             done
);

  localparam logic [ADC_W-1:0] LAST = ADC_W'(NUM_SAMPLES - 1);
  localparam int SHIFT = DAC_W - ADC_W;
  localparam int SPAN  = 3 * DITH_STEP;

  int dac_i;
  int base_i;
  always_comb begin
    dac_i  = int'(dac_code);
    base_i = int'(adc_code) << SHIFT;
  end

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (out_valid && adc_code == '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start_i) |=>
      (out_valid && $stable(adc_code) && $stable(dac_code)));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !start_i && adc_code != LAST) |=>
      (out_valid && adc_code == $past(adc_code) + 1'b1));

  // R5
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (dac_i + SPAN >= base_i && dac_i <= base_i + SPAN));

  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && out_valid));

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done);

endmodule

bind ramp_dither_gen ramp_dither_chk #(
  .DAC_W       (DAC_W),
  .ADC_W       (ADC_W),
  .DITH_STEP   (DITH_STEP),
  .NUM_SAMPLES (NUM_SAMPLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .dac_code  (dac_code),
  .adc_code  (adc_code),
  .done      (done)
);

// File: tb/tb_ramp_dither_gen.sv
module tb_ramp_dither_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic out_ready = 1'b0;

  logic        out_valid, done;
  logic [19:0] dac_code;
  logic [11:0] adc_code;
  logic        hv_valid, hv_done;
  logic [11:0] hv_dac, hv_adc;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int m_run, m_ramp, m_st, m_done;

  always #5 clk = ~clk;

  ramp_dither_gen dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .out_ready(out_ready),
    .out_valid(out_valid), .dac_code(dac_code), .adc_code(adc_code), .done(done)
  );

  // equal widths and a larger step so the upper clamp is reachable
  ramp_dither_gen #(.DAC_W(12), .ADC_W(12), .DITH_STEP(4)) dut_hi (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .out_ready(out_ready),
    .out_valid(hv_valid), .dac_code(hv_dac), .adc_code(hv_adc), .done(hv_done)
  );

  function automatic int nxt(input int s);
    int b2 = (s >> 2) & 1;
    int b1 = (s >> 1) & 1;
    return ((s << 1) & 6) | (b2 ^ b1);
  endfunction

  function automatic int exp_dac(input int r, input int s, input int sh,
                                 input int stp, input int dw);
    int v = (r << sh) + (s - 4) * stp;
    int mx = (1 << dw) - 1;
    if (v < 0) v = 0;
    if (v > mx) v = mx;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1,R6 valid", int'(out_valid), m_run);
    chk("R6 done", int'(done), m_done);
    chk("R6 hi done", int'(hv_done), m_done);
    if (m_run != 0) begin
      chk("R3 adc_code", int'(adc_code), m_ramp);
      chk("R4 dac_code", int'(dac_code), exp_dac(m_ramp, m_st, 8, 32, 20));
      chk("R5 hi dac_code", int'(hv_dac), exp_dac(m_ramp, m_st, 0, 4, 12));
    end
  endtask

  // inputs for the next edge; model advanced accordingly; check after edge
  task automatic tick(input bit s, input bit r);
    start_i = s;
    out_ready = r;
    if (s) begin
      m_run = 1; m_ramp = 0; m_st = 1; m_done = 0;
    end else if (m_run != 0 && r) begin
      if (m_ramp == 4095) begin
        m_run = 0; m_done = 1;
      end else begin
        m_ramp++;
      end
      m_st = nxt(m_st);
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_seq[8] = '{0, 192, 544, 736, 1120, 1344, 1536, 1696};
    void'($urandom(32'h5eed_1234));
    m_run = 0; m_ramp = 0; m_st = 1; m_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, ready while idle has no effect
    compare_all();
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1);
    chk("R1 idle valid", int'(out_valid), 0);

    // R2, R4, R5: first samples with ready held high
    tick(1'b1, 1'b0);
    chk("R2 first adc", int'(adc_code), 0);
    chk("R5 low clamp", int'(dac_code), 0);
    for (int i = 1; i < 8; i++) begin
      tick(1'b0, 1'b1);
      chk("R4 pattern", int'(dac_code), exp_seq[i]);
    end
    // R3: stall holds
    for (int i = 0; i < 4; i++) begin
      tick(1'b0, 1'b0);
      chk("R3 stall adc", int'(adc_code), 7);
      chk("R3 stall dac", int'(dac_code), 1696);
    end
    // R7: restart mid-run
    tick(1'b1, 1'b1);
    chk("R7 restart adc", int'(adc_code), 0);
    tick(1'b0, 1'b1);
    chk("R7 restart dac", int'(dac_code), 192);

    // random back-pressure with occasional restarts
    for (int i = 0; i < 400; i++)
      tick(($urandom % 64) == 0, ($urandom % 3) != 0);

    // full run to completion under random back-pressure
    tick(1'b1, 1'b0);
    while (m_run != 0) begin
      bit r = ($urandom % 4) != 0;
      if (m_ramp == 4092 && r) begin
        tick(1'b0, 1'b0);
        chk("R5 upper clamp", int'(hv_dac), 4095);
      end
      tick(1'b0, r);
    end
    chk("R6 done raised", int'(done), 1);
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b1);
    chk("R6 done held", int'(done), 1);
    chk("R6 valid low", int'(out_valid), 0);

    // R8: start after completion
    tick(1'b1, 1'b1);
    chk("R8 done cleared", int'(done), 0);
    chk("R8 new run", int'(out_valid), 1);
    for (int i = 0; i < 20; i++) tick(1'b0, ($urandom % 2) != 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule